// File: doc/BRIEF.md
# Multichannel ADC Conversion Controller

This block sits between a 32-bit register bus and an external successive-approximation converter core. Software writes a control word that picks one of sixteen inputs, a conversion clock ratio, a power bit, a converter reset bit, a start bit and a single or continuous mode. The controller derives the converter clock from the system clock and issues a one-cycle start strobe to the core. It then waits for the core's completion pulse and captures the 10-bit result.

Each finished conversion sets a ready flag for its channel. Ready flags and interrupt enables share one status word. The interrupt line stays high while any channel has both its flag and its enable set. Software acknowledges a result by writing the whole status word back with the flag bits it wants cleared set to zero. In continuous mode the controller launches the next conversion on the same channel as soon as the previous result has been captured.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control, status and result registers read 0, and `irq`, `cnv_clk` and `cnv_start` are low.
- R2: The control word is at offset 0x14. Its fields are: channel in bits [8:5], power in bit 9, clock ratio in bits [11:10], start in bit 12, converter reset in bit 13 and continuous mode in bit 15. All other bits read back as 0. `cnv_pwr` and `cnv_rst` follow bits 9 and 13.
- R3: While powered and out of converter reset, `cnv_clk` rises once every 2, 3, 4 or 8 system cycles for ratio codes 0, 1, 2 and 3. Otherwise it stays low.
- R4: Raising the start bit while powered gives exactly one `cnv_start` pulse with `cnv_chan` equal to the selected channel. The completion data appears in bits [9:0] of the result register at offset 0x20.
- R5: In single mode, no further conversion begins while the start bit stays 1. A new one begins only after software clears the bit and sets it again.
- R6: While the power bit is 0, no conversion starts. A start bit set while power is off is ignored, even after power is later turned on, until the start bit is cleared and set again.
- R7: In continuous mode, the next conversion on the same channel starts on the cycle the previous result is captured, and each result overwrites the result register. Clearing the start bit lets the conversion in progress finish and then stops.
- R8: The status word is at offset 0x1C. Bit n (n = 0..15) is channel n's ready flag and bit 16+n is its interrupt enable. A write replaces both fields with the written value; it is not write-one-to-clear.
- R9: `irq` is high exactly while some channel has both its ready flag and its enable set.
- R10: If the core reports completion in the same cycle as a status write that would clear that channel's flag, the flag ends up set.
- R11: While the converter reset bit is 1, `cnv_rst` is high, the converter clock is stopped and no conversion starts. A start bit that was held through reset needs to be cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cnv_clk | output | 1 | Divided converter clock |
| cnv_pwr | output | 1 | Converter power enable |
| cnv_rst | output | 1 | Converter reset |
| cnv_chan | output | 4 | Channel of the current conversion |
| cnv_start | output | 1 | One-cycle start strobe to the converter |
| cnv_done | input | 1 | One-cycle completion pulse from the converter |
| cnv_data | input | 10 | Conversion result, valid with `cnv_done` |
| irq | output | 1 | Level interrupt |

## Verification
Conversions are requested in single mode with the start bit held high after completion. This shows whether the controller waits for a fresh rising start instead of retriggering. The same sequence with power off, and again under converter reset, shows that a start level alone is never enough. A continuous run of three conversions, with start dropped during the third, separates correct re-triggering from runaway or missing conversions. A scoreboard of expected channels catches any extra or misrouted strobe. Status writes with various flag and enable patterns, including one timed onto a completion pulse, show that writes replace the flags, that the interrupt tracks the flag-and-enable overlap, and that a completion wins over a clearing write.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int          ADDR_W    = 8,
  parameter int          RES_W     = 10,
  parameter logic [7:0]  CTRL_OFS  = 8'h14,
  parameter logic [7:0]  STAT_OFS  = 8'h1C,
  parameter logic [7:0]  DATA_OFS  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cnv_clk,
  output logic              cnv_pwr,
  output logic              cnv_rst,
  output logic [3:0]        cnv_chan,
  output logic              cnv_start,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_data,
  output logic              irq
);
  localparam int          NCH       = 16;
  localparam logic [31:0] CTRL_MASK = 32'h0000_BFE0;

  logic [31:0]      ctrl_q;
  logic [NCH-1:0]   ready_q, ien_q;
  logic [RES_W-1:0] result_q;
  logic [3:0]       div_cnt, div_n, cnt_nxt, cur_ch;
  logic             clk_q, busy_q, armed_q, start_q;

  wire [3:0] sel_ch  = ctrl_q[8:5];
  wire       pwr     = ctrl_q[9];
  wire [1:0] div_sel = ctrl_q[11:10];
  wire       go      = ctrl_q[12];
  wire       crst    = ctrl_q[13];
  wire       cont    = ctrl_q[15];
  wire       active  = pwr & ~crst;

  wire ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
  wire stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_OFS));
  wire capture = busy_q & cnv_done;
  wire launch  = active & go & (busy_q ? (cnv_done & cont) : armed_q);

  always_comb begin
    case (div_sel)
      2'd0:    div_n = 4'd2;
      2'd1:    div_n = 4'd3;
      2'd2:    div_n = 4'd4;
      default: div_n = 4'd8;
    endcase
    cnt_nxt = (div_cnt >= div_n - 4'd1) ? 4'd0 : div_cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      div_cnt <= '0;
      clk_q   <= 1'b0;
    end else begin
      div_cnt <= cnt_nxt;
      clk_q   <= cnt_nxt < (div_n >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      armed_q <= 1'b1;
      start_q <= 1'b0;
      cur_ch  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_MASK;
      start_q <= launch;
      if (launch) cur_ch <= sel_ch;
      if (!go) armed_q <= 1'b1;
      else if (launch || !active) armed_q <= 1'b0;
      if (!active) busy_q <= 1'b0;
      else if (launch) busy_q <= 1'b1;
      else if (cnv_done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= '0;
      ien_q    <= '0;
      result_q <= '0;
    end else begin
      if (stat_wr) ien_q <= reg_wdata[31:16];
      if (capture) result_q <= cnv_data;
      for (int i = 0; i < NCH; i++) begin
        if (capture && cur_ch == 4'(i)) ready_q[i] <= 1'b1;
        else if (stat_wr)               ready_q[i] <= reg_wdata[i];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_OFS))      reg_rdata = ctrl_q;
    else if (reg_addr == ADDR_W'(STAT_OFS)) reg_rdata = {ien_q, ready_q};
    else if (reg_addr == ADDR_W'(DATA_OFS)) reg_rdata = 32'(result_q);
  end

  assign cnv_clk   = clk_q;
  assign cnv_pwr   = pwr;
  assign cnv_rst   = crst;
  assign cnv_chan  = cur_ch;
  assign cnv_start = start_q;
  assign irq       = |(ready_q & ien_q);

  p_start_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> $past(pwr) && !$past(crst));
  p_start_marks_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> busy_q);
  p_flag_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ready_q[$past(cur_ch)]);
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result_q));
  p_clk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active) |-> !cnv_clk);
  p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !capture) |=> !cnv_start);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  localparam int LAT = 6;
  logic clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic cnv_clk, cnv_pwr, cnv_rst, cnv_start, irq;
  logic [3:0] cnv_chan;
  logic cnv_done = 0;
  logic [9:0] cnv_data = 0, last_data = 0;
  int stub_cnt = 0, stub_n = 0, starts_seen = 0, checks = 0, errors = 0;
  logic [3:0] exp_q[$];

  always #4 clk = ~clk;

  adc_seq_ctrl dut_i (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .cnv_clk, .cnv_pwr, .cnv_rst, .cnv_chan, .cnv_start, .cnv_done, .cnv_data, .irq);

  // converter stub: completion LAT cycles after the strobe
  always @(posedge clk) begin
    cnv_done <= 1'b0;
    if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin
        cnv_done  <= 1'b1;
        cnv_data  <= 10'((stub_n * 73 + 5) & 10'h3FF);
        last_data <= 10'((stub_n * 73 + 5) & 10'h3FF);
        stub_n    <= stub_n + 1;
      end
    end
    if (cnv_start) stub_cnt <= LAT;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match an expected channel
  always @(negedge clk) begin
    if (rst_n && cnv_start) begin
      starts_seen++;
      if (exp_q.size() == 0) chk("R5 unexpected start", 32'(cnv_chan), 32'hFFFF_FFFF);
      else chk("R4 strobe channel", 32'(cnv_chan), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    while (cnv_done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  function automatic logic [31:0] cw(int ch, bit p, bit s, bit r = 0, bit c = 0, int d = 0);
    return (32'(ch) << 5) | (32'(p) << 9) | (32'(d) << 10) | (32'(s) << 12) |
           (32'(r) << 13) | (32'(c) << 15);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, prev, per;
    int exp_per[4] = '{2, 3, 4, 8};
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(8'h14, v); chk("R1 ctrl", v, 0);
    rd(8'h1C, v); chk("R1 status", v, 0);
    rd(8'h20, v); chk("R1 result", v, 0);
    chk("R1 outputs", {irq, cnv_clk, cnv_start}, 0);
    // R2
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R2 readback", v, 32'h0000_BFE0);
    chk("R2 pwr/rst pins", {cnv_pwr, cnv_rst}, 2'b11);
    wr(8'h14, 0);
    rd(8'h14, v); chk("R2 cleared", v, 0);
    // R3 clock ratios
    for (int d = 0; d < 4; d++) begin
      wr(8'h14, cw(0, 1, 0, 0, 0, d));
      repeat (10) @(negedge clk);
      prev = -1; per = 0;
      for (int t = 0, last = 0; t < 40; t++) begin
        @(negedge clk);
        if (cnv_clk && !last) begin
          if (prev >= 0) per = t - prev;
          prev = t;
        end
        last = cnv_clk;
      end
      chk("R3 period", per, exp_per[d]);
    end
    wr(8'h14, 0);
    v = 0;
    for (int t = 0; t < 16; t++) begin @(negedge clk); v |= 32'(cnv_clk); end
    chk("R3 clock off unpowered", v, 0);
    // R6 power off
    base = starts_seen;
    wr(8'h14, cw(3, 0, 1));
    repeat (20) @(negedge clk);
    chk("R6 no start unpowered", starts_seen, base);
    wr(8'h14, cw(3, 1, 1));
    repeat (20) @(negedge clk);
    chk("R6 stale start ignored", starts_seen, base);
    wr(8'h14, cw(3, 1, 0));
    // R4 single conversion, R9 irq
    wr(8'h1C, 32'h1 << 21);
    exp_q.push_back(5);
    wr(8'h14, cw(5, 1, 1));
    wait_done();
    chk("R4 one start", starts_seen, base + 1);
    rd(8'h20, v); chk("R4 result", v, 32'(last_data));
    rd(8'h1C, v); chk("R4 ready flag ch5", v, 32'h0020_0020);
    chk("R9 irq on enabled flag", irq, 1);
    // R5 held start
    repeat (30) @(negedge clk);
    chk("R5 no retrigger", starts_seen, base + 1);
    wr(8'h1C, 32'h0020_0000);
    rd(8'h1C, v); chk("R8 ack clears flag", v, 32'h0020_0000);
    chk("R9 irq low after ack", irq, 0);
    wr(8'h14, cw(9, 1, 0));
    exp_q.push_back(9);
    wr(8'h14, cw(9, 1, 1));
    wait_done();
    chk("R5 retrigger after toggle", starts_seen, base + 2);
    rd(8'h20, v); chk("R5 result", v, 32'(last_data));
    rd(8'h1C, v); chk("R8 ready ch9", v, 32'h0020_0200);
    chk("R9 irq masked", irq, 0);
    // R8 replace semantics
    wr(8'h1C, 32'h0005_000A);
    rd(8'h1C, v); chk("R8 write replaces", v, 32'h0005_000A);
    chk("R9 no overlap", irq, 0);
    wr(8'h1C, 32'h0002_000A);
    chk("R9 overlap", irq, 1);
    wr(8'h1C, 0);
    chk("R9 cleared", irq, 0);
    // R10 completion beats clearing write
    wr(8'h14, cw(2, 1, 0));
    exp_q.push_back(2);
    wr(8'h14, cw(2, 1, 1));
    for (int n = 0; n < 100 && cnv_done !== 1'b1; n++) @(negedge clk);
    wr(8'h1C, 0);
    rd(8'h1C, v); chk("R10 flag wins", v, 32'h0000_0004);
    // R7 continuous
    wr(8'h14, cw(7, 1, 0));
    wr(8'h1C, 0);
    base = starts_seen;
    repeat (3) exp_q.push_back(7);
    wr(8'h14, cw(7, 1, 1, 0, 1));
    for (int n = 0; n < 200 && starts_seen < base + 3; n++) @(negedge clk);
    wr(8'h14, cw(7, 1, 0, 0, 1));
    wait_done();
    repeat (20) @(negedge clk);
    chk("R7 three conversions", starts_seen, base + 3);
    rd(8'h20, v); chk("R7 latest result", v, 32'(last_data));
    rd(8'h1C, v); chk("R7 ready ch7", v, 32'h0000_0080);
    // R11 converter reset
    base = starts_seen;
    wr(8'h14, cw(1, 1, 0));
    wr(8'h14, cw(1, 1, 1, 1));
    chk("R11 rst pin", cnv_rst, 1);
    repeat (20) @(negedge clk);
    chk("R11 clock stopped", cnv_clk, 0);
    chk("R11 no start in reset", starts_seen, base);
    wr(8'h14, cw(1, 1, 1));
    repeat (20) @(negedge clk);
    chk("R11 stale start after reset", starts_seen, base);
    wr(8'h14, cw(1, 1, 0));
    exp_q.push_back(1);
    wr(8'h14, cw(1, 1, 1));
    wait_done();
    chk("R11 start after toggle", starts_seen, base + 1);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule